// File: doc/BRIEF.md
# Two-Operand Execution Unit

This unit is the arithmetic and shift stage of a small 16-bit processor whose instructions name at most two registers. The first register operand is both a source and the destination. The unit takes the values of both register operands, an 8-bit immediate, a 4-bit shift count, a 4-bit opcode and a single variant bit. From these it forms the value that the processor writes back into the first register. A single opcode carries two related operations, and the variant bit picks between them:

- add or subtract;
- AND or NOR;
- immediate add with zero or sign extension;
- logical left or right shift.

The unit also reports whether the first register operand is zero, for the conditional branch logic. Both outputs are registered, so they present the outcome of the operands sampled at the previous rising clock edge. Carry and overflow are dropped, and no flags are kept between operations. Opcodes outside the arithmetic group pass the first operand through unchanged.

Top module: `twoop_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next values of `wb_data` and `src_is_zero` are 0.
- R2: Opcode 4'b0001 with `variant`=0 gives `src_a + src_b` modulo 2^16; the carry out is lost.
- R3: Opcode 4'b0001 with `variant`=1 gives `src_a - src_b` modulo 2^16, so a borrow wraps around.
- R4: Opcode 4'b0011 with `variant`=0 gives the bitwise AND of `src_a` and `src_b`.
- R5: Opcode 4'b0011 with `variant`=1 gives the bitwise NOR of `src_a` and `src_b`.
- R6: Opcode 4'b0010 with `variant`=1 adds `imm8` to `src_a` after copying bit 7 of `imm8` into bits 15..8.
- R7: Opcode 4'b0010 with `variant`=0 adds `imm8` to `src_a` after filling bits 15..8 with zeros.
- R8: Opcode 4'b0100 with `variant`=0 shifts `src_a` left by `shamt` (0 to 15) places and fills with zeros.
- R9: Opcode 4'b0100 with `variant`=1 shifts `src_a` right by `shamt` places and fills with zeros, including from bit 15.
- R10: `src_is_zero` is 1 exactly when `src_a` was 0 at the previous edge, whatever the opcode and whatever the result.
- R11: Any opcode other than 4'b0001, 4'b0010, 4'b0011 or 4'b0100 gives `src_a` unchanged. `src_b`, `imm8`, `shamt` and `variant` have no effect for these opcodes.
- R12: Outputs change only at a rising edge. They show the operation on the inputs present at that edge (one cycle of latency), and `src_b`, `imm8` and `shamt` play no part in operations that do not use them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| src_a | input | 16 | First register operand, also the destination |
| src_b | input | 16 | Second register operand |
| imm8 | input | 8 | Immediate field |
| shamt | input | 4 | Unsigned shift count |
| opcode | input | 4 | Operation group |
| variant | input | 1 | Picks one of the two operations in a group |
| wb_data | output | 16 | Registered write-back value |
| src_is_zero | output | 1 | Registered flag: first operand was zero |

## Verification
The checker assumes that every input holds a known 0/1 value at each rising edge. It also assumes that reset is held high across at least one edge before results are compared. The functional properties stay disabled until one full edge after reset has been released. Arbitrary opcodes are allowed, since the pass-through rule covers the reserved codes. The directed stimulus drives every input on the falling edge, with no unknown values, and it applies reset with nonzero operands present. This shows that reset wins over a live operation.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int DATA_W  = 16;
  localparam int IMM_W   = 8;
  localparam int SHAMT_W = 4;
  localparam int OPC_W   = 4;

  localparam logic [OPC_W-1:0] OPC_ARITH = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_IMMADD = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_LOGIC = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_SHIFT = 4'b0100;

  typedef enum logic [1:0] {
    PICK_PASS  = 2'd0,
    PICK_SUM   = 2'd1,
    PICK_LOGIC = 2'd2,
    PICK_SHIFT = 2'd3
  } pick_e;
endpackage

// File: rtl/exu_operand_sel.sv
module exu_operand_sel #(
  parameter int W  = 16,
  parameter int IW = 8
) (
  input  logic [W-1:0]  reg_b,
  input  logic [IW-1:0] imm,
  input  logic          use_imm,
  input  logic          sext,
  output logic [W-1:0]  opnd_b
);
  localparam int PAD = W - IW;

  logic [W-1:0] imm_wide;

  always_comb begin
    if (sext) imm_wide = {{PAD{imm[IW-1]}}, imm};
    else      imm_wide = {{PAD{1'b0}}, imm};
    opnd_b = use_imm ? imm_wide : reg_b;
  end
endmodule

// File: rtl/exu_arith.sv
module exu_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         subtract,
  input  logic         nor_mode,
  output logic [W-1:0] sum,
  output logic [W-1:0] bitwise
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff   = subtract ? ~b : b;
    sum     = a + b_eff + W'(subtract);
    bitwise = nor_mode ? ~(a | b) : (a & b);
  end
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
  parameter int W  = 16,
  parameter int SW = 4
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          to_right,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [SW+1];

  assign stage[0] = din;

  generate
    for (genvar k = 0; k < SW; k++) begin : g_stage
      localparam int DIST = 1 << k;
      logic [W-1:0] moved;
      assign moved = to_right ? (stage[k] >> DIST) : (stage[k] << DIST);
      assign stage[k+1] = amt[k] ? moved : stage[k];
    end
  endgenerate

  assign dout = stage[SW];
endmodule

// File: rtl/twoop_exec_unit.sv
module twoop_exec_unit
  import exu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = IMM_W,
  parameter int SW = SHAMT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  src_a,
  input  logic [W-1:0]  src_b,
  input  logic [IW-1:0] imm8,
  input  logic [SW-1:0] shamt,
  input  logic [OPC_W-1:0] opcode,
  input  logic          variant,
  output logic [W-1:0]  wb_data,
  output logic          src_is_zero
);
  pick_e        pick;
  logic         use_imm;
  logic         do_sub;
  logic [W-1:0] opnd_b;
  logic [W-1:0] sum_v;
  logic [W-1:0] logic_v;
  logic [W-1:0] shift_v;
  logic [W-1:0] next_wb;

  always_comb begin
    pick    = PICK_PASS;
    use_imm = 1'b0;
    do_sub  = 1'b0;
    unique case (opcode)
      OPC_ARITH: begin
        pick   = PICK_SUM;
        do_sub = variant;
      end
      OPC_IMMADD: begin
        pick    = PICK_SUM;
        use_imm = 1'b1;
      end
      OPC_LOGIC: pick = PICK_LOGIC;
      OPC_SHIFT: pick = PICK_SHIFT;
      default:   pick = PICK_PASS;
    endcase
  end

  exu_operand_sel #(.W(W), .IW(IW)) u_opsel (
    .reg_b   (src_b),
    .imm     (imm8),
    .use_imm (use_imm),
    .sext    (variant),
    .opnd_b  (opnd_b)
  );

  exu_arith #(.W(W)) u_arith (
    .a        (src_a),
    .b        (opnd_b),
    .subtract (do_sub),
    .nor_mode (variant),
    .sum      (sum_v),
    .bitwise  (logic_v)
  );

  exu_shifter #(.W(W), .SW(SW)) u_shift (
    .din      (src_a),
    .amt      (shamt),
    .to_right (variant),
    .dout     (shift_v)
  );

  always_comb begin
    unique case (pick)
      PICK_SUM:   next_wb = sum_v;
      PICK_LOGIC: next_wb = logic_v;
      PICK_SHIFT: next_wb = shift_v;
      default:    next_wb = src_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_data     <= '0;
      src_is_zero <= 1'b0;
    end else begin
      wb_data     <= next_wb;
      src_is_zero <= (src_a == '0);
    end
  end
endmodule

// File: rtl/twoop_exec_unit_chk.sv
module twoop_exec_unit_chk #(
  parameter int W  = 16,
  parameter int IW = 8,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  src_a,
  input logic [W-1:0]  src_b,
  input logic [IW-1:0] imm8,
  input logic [SW-1:0] shamt,
  input logic [3:0]    opcode,
  input logic          variant,
  input logic [W-1:0]  wb_data,
  input logic          src_is_zero
);
  logic rst_d = 1'b0;
  logic live  = 1'b0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    live  <= !rst;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst_d |-> (wb_data == '0 && !src_is_zero));

  // R2
  add_wrap_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(opcode) == 4'b0001 && !$past(variant)) |->
      wb_data == W'($past(src_a) + $past(src_b)));

  // R3
  sub_wrap_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(opcode) == 4'b0001 && $past(variant)) |->
      wb_data == W'($past(src_a) - $past(src_b)));

  // R4
  and_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(opcode) == 4'b0011 && !$past(variant)) |->
      wb_data == ($past(src_a) & $past(src_b)));

  // R5
  nor_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(opcode) == 4'b0011 && $past(variant)) |->
      wb_data == ~($past(src_a) | $past(src_b)));

  // R6
  imm_sext_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(opcode) == 4'b0010 && $past(variant)) |->
      wb_data == W'($past(src_a) + W'($signed($past(imm8)))));

  // R7
  imm_zext_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(opcode) == 4'b0010 && !$past(variant)) |->
      wb_data == W'($past(src_a) + W'($past(imm8))));

  // R8
  shl_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(opcode) == 4'b0100 && !$past(variant)) |->
      wb_data == ($past(src_a) << $past(shamt)));

  // R9
  shr_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(opcode) == 4'b0100 && $past(variant)) |->
      wb_data == ($past(src_a) >> $past(shamt)));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst || !live)
    src_is_zero == ($past(src_a) == '0));

  // R11
  passthru_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(opcode) > 4'b0100 || $past(opcode) == 4'b0000) |->
      wb_data == $past(src_a));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(rst) == 1'b0 && $stable(src_a) && $stable(src_b) && $stable(imm8) &&
     $stable(shamt) && $stable(opcode) && $stable(variant) && !$past(rst, 2))
      |=> $stable(wb_data));
endmodule

bind twoop_exec_unit twoop_exec_unit_chk #(.W(W), .IW(IW), .SW(SW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .src_a       (src_a),
  .src_b       (src_b),
  .imm8        (imm8),
  .shamt       (shamt),
  .opcode      (opcode),
  .variant     (variant),
  .wb_data     (wb_data),
  .src_is_zero (src_is_zero)
);

// File: tb/twoop_exec_unit_bench.sv
module twoop_exec_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_a = 16'h1234;
  logic [15:0] src_b = 16'h4321;
  logic [7:0]  imm8 = 8'h55;
  logic [3:0]  shamt = 4'd3;
  logic [3:0]  opcode = 4'b0001;
  logic        variant = 1'b0;
  logic [15:0] wb_data;
  logic        src_is_zero;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twoop_exec_unit u_twoop_exec_unit (
    .clk         (clk),
    .rst         (rst),
    .src_a       (src_a),
    .src_b       (src_b),
    .imm8        (imm8),
    .shamt       (shamt),
    .opcode      (opcode),
    .variant     (variant),
    .wb_data     (wb_data),
    .src_is_zero (src_is_zero)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic sub, input logic [15:0] a,
                        input logic [15:0] b, input logic [7:0] im, input logic [3:0] sh);
    @(negedge clk);
    opcode = op; variant = sub; src_a = a; src_b = b; imm8 = im; shamt = sh;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    // R1: reset wins over a live add with nonzero operands
    repeat (2) @(posedge clk);
    #1;
    check("R1 result", wb_data, 16'h0000);
    check("R1 zero", {15'b0, src_is_zero}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_addsub;
    run_op(4'b0001, 1'b0, 16'h1234, 16'h0F0F, 8'hFF, 4'hF);
    check("R2 add", wb_data, 16'h2143);
    run_op(4'b0001, 1'b0, 16'hFFFF, 16'h0001, 8'h00, 4'h0);
    check("R2 carry lost", wb_data, 16'h0000);
    run_op(4'b0001, 1'b1, 16'h0000, 16'h0001, 8'h00, 4'h0);
    check("R3 borrow wrap", wb_data, 16'hFFFF);
    run_op(4'b0001, 1'b1, 16'h8000, 16'h0001, 8'h12, 4'h7);
    check("R3 sub", wb_data, 16'h7FFF);
  endtask

  task automatic t_logic;
    run_op(4'b0011, 1'b0, 16'hF0F0, 16'hFF00, 8'h00, 4'h1);
    check("R4 and", wb_data, 16'hF000);
    run_op(4'b0011, 1'b1, 16'hF0F0, 16'hFF00, 8'h00, 4'h1);
    check("R5 nor", wb_data, 16'h000F);
    run_op(4'b0011, 1'b1, 16'h0000, 16'h0000, 8'hAA, 4'h2);
    check("R5 nor zeros", wb_data, 16'hFFFF);
  endtask

  task automatic t_immadd;
    run_op(4'b0010, 1'b1, 16'h0100, 16'hAAAA, 8'h80, 4'h0);
    check("R6 sext neg", wb_data, 16'h0080);
    run_op(4'b0010, 1'b1, 16'h0005, 16'h0000, 8'hFF, 4'h0);
    check("R6 sext -1", wb_data, 16'h0004);
    run_op(4'b0010, 1'b0, 16'h0100, 16'hAAAA, 8'h80, 4'h0);
    check("R7 zext", wb_data, 16'h0180);
    run_op(4'b0010, 1'b0, 16'hFFFF, 16'h0000, 8'h01, 4'h0);
    check("R7 wrap", wb_data, 16'h0000);
  endtask

  task automatic t_shift;
    run_op(4'b0100, 1'b0, 16'h00F1, 16'hFFFF, 8'hFF, 4'd4);
    check("R8 shl 4", wb_data, 16'h0F10);
    run_op(4'b0100, 1'b0, 16'h0003, 16'h0000, 8'h00, 4'd15);
    check("R8 shl 15", wb_data, 16'h8000);
    run_op(4'b0100, 1'b0, 16'hBEEF, 16'h0000, 8'h00, 4'd0);
    check("R8 shl 0", wb_data, 16'hBEEF);
    run_op(4'b0100, 1'b1, 16'h8000, 16'hFFFF, 8'hFF, 4'd15);
    check("R9 shr 15 logical", wb_data, 16'h0001);
    run_op(4'b0100, 1'b1, 16'hF00F, 16'h0000, 8'h00, 4'd4);
    check("R9 shr 4", wb_data, 16'h0F00);
  endtask

  task automatic t_zero;
    run_op(4'b0001, 1'b0, 16'h0000, 16'h0007, 8'h00, 4'h0);
    check("R10 zero set", {15'b0, src_is_zero}, 16'h0001);
    check("R10 result nonzero", wb_data, 16'h0007);
    run_op(4'b0001, 1'b1, 16'h0009, 16'h0009, 8'h00, 4'h0);
    check("R10 zero clear", {15'b0, src_is_zero}, 16'h0000);
    check("R10 result zero", wb_data, 16'h0000);
  endtask

  task automatic t_pass;
    run_op(4'b1000, 1'b1, 16'hCAFE, 16'h1111, 8'h22, 4'h3);
    check("R11 op8", wb_data, 16'hCAFE);
    run_op(4'b1111, 1'b0, 16'h1357, 16'hFFFF, 8'hFF, 4'hF);
    check("R11 opF", wb_data, 16'h1357);
    run_op(4'b0000, 1'b1, 16'h0042, 16'h9999, 8'h80, 4'h8);
    check("R11 op0", wb_data, 16'h0042);
  endtask

  task automatic t_latency;
    // R12: result appears after the edge, stays until the next edge, unused inputs ignored
    run_op(4'b0011, 1'b0, 16'h00FF, 16'h0F0F, 8'h00, 4'h0);
    @(negedge clk);
    opcode = 4'b0001; src_a = 16'h0001; src_b = 16'h0001;
    #1;
    check("R12 held before edge", wb_data, 16'h000F);
    @(posedge clk);
    #1;
    check("R12 updated", wb_data, 16'h0002);
    run_op(4'b0001, 1'b0, 16'h0001, 16'h0001, 8'hAB, 4'hC);
    check("R12 imm/shamt ignored", wb_data, 16'h0002);
  endtask

  initial begin
    t_reset();
    t_addsub();
    t_logic();
    t_immadd();
    t_shift();
    t_zero();
    t_pass();
    t_latency();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule